// File: doc/BRIEF.md
# Triplex LCD Scan Driver

This block drives a three-backplane multiplexed liquid crystal display from 36 latched display bits. A frame timer divides each frame into three equal backplane phases, and each phase has two halves. On every cycle the block gives a 2-bit drive-level code for each of the three backplane pins and each of the twelve segment pins. A fixed mapping table chooses, for each segment pin, which display bit is shown during the phase of each backplane. The analog stage outside the block turns each level code into one of four bias voltages.

A 2-bit role field sets how the device works with other devices. In stand-alone and master roles, the timer steps on an internal oscillator tick. In slave role, it steps on rising edges of an oscillator input. In some roles, the first backplane pin becomes an oscillator input, or the third backplane pin carries the oscillator out to slaves. A synchronising write puts the timer back to the start of a frame, so cascaded devices stay aligned.

Top module: `lcd_scan_driver`

## Requirements
- R1: Synchronous active-high reset puts the timer at the start of a frame: the first backplane is in the first half of its phase.
- R2: Each phase lasts PHASE_LEN timer steps (default 64). The phases run first, second, third backplane and then wrap, so a frame is 3*PHASE_LEN steps.
- R3: Level codes: 0 is ground, 1 is one third, 2 is two thirds, 3 is full supply. The active backplane is 3 in the first half of its phase and 0 in the second half. An idle backplane is 1 in the first half and 2 in the second half.
- R4: A lit segment is at code 0 in the first half and code 3 in the second half. A dark segment is at 2 in the first half and 1 in the second half.
- R5: Bit numbering: for digit d (0..3), byte offsets are counted from bit 8d of seg_bits. Pin A of digit d shows offset 6 during the first phase, 5 during the second and 0 during the third. Pin B shows 7, 1 and 4. Pin C shows 2 and 3 during the first two phases. seg_code pin index is 4*kind+d, with kind 0=A, 1=B, 2=C.
- R6: During the third phase, pin C of digit d shows special bit seg_bits[32+d].
- R7: With role 11 (slave), the timer steps once per rising edge of ext_osc, and osc_tick is ignored. In every other role, it steps once per cycle with osc_tick high.
- R8: sync_wr high returns the timer to the start of a frame at the next edge, even if a step is also due.
- R9: With role 00 or 10, pin_c_osc is high, and the third backplane code is 3 in the cycle after an osc_tick and 0 otherwise.
- R10: With role 10 or 11, pin_a_oe is low and the first backplane code is 0. With role 00 or 01, pin_a_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Internal oscillator step pulse |
| ext_osc | input | 1 | Oscillator input level from a master (slave role) |
| mode | input | 2 | Role field {hi, lo}: 00 master, 01 stand-alone, 10 reserved, 11 slave |
| sync_wr | input | 1 | Frame restart pulse |
| seg_bits | input | 9*DIGITS | Latched display bits |
| bp_code | output | 6 | Backplane level codes, 2 bits each, first backplane in bits 1:0 |
| seg_code | output | 6*DIGITS | Segment level codes, 2 bits per pin, pin index 4*kind+d |
| pin_a_oe | output | 1 | First backplane pin is driven as a backplane |
| pin_c_osc | output | 1 | Third backplane pin carries the oscillator out |

## Verification
A step due at a clock edge (an osc_tick, or an ext_osc rise seen against the level it had one edge earlier) moves the timer at that edge. The timer feeds the level codes through logic only, so the new codes show up in the same cycle. Role and seg_bits feed the outputs combinationally, and the oscillator copy on the third backplane comes one cycle after its tick. The bench drives inputs just after the rising edge. Its model advances on the same edge, and every output is compared at the following falling edge, which is exactly when each result is due.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LVL_GND   = 2'd0,
        LVL_THIRD = 2'd1,
        LVL_TWO3  = 2'd2,
        LVL_FULL  = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ROLE_MASTER = 2'b00,
        ROLE_ALONE  = 2'b01,
        ROLE_RSVD   = 2'b10,
        ROLE_SLAVE  = 2'b11
    } role_e;

    typedef struct packed {
        logic [1:0] phase;   // 0,1,2 = first, second, third backplane
        logic       late;    // second half of the phase
    } scan_pos_t;

    typedef struct packed {
        logic use_ext;   // step on external oscillator edges
        logic a_drive;   // first backplane pin driven
        logic c_osc;     // third backplane pin carries oscillator
    } pin_cfg_t;

    function automatic pin_cfg_t decode_role(role_e r);
        pin_cfg_t c;
        c.use_ext = (r == ROLE_SLAVE);
        c.a_drive = (r == ROLE_MASTER) || (r == ROLE_ALONE);
        c.c_osc   = (r == ROLE_MASTER) || (r == ROLE_RSVD);
        return c;
    endfunction

    // kind: 0 = pin A, 1 = pin B, 2 = pin C of a digit; phase: backplane index
    function automatic int unsigned map_bit(int unsigned kind, int unsigned digit,
                                            int unsigned phase, int unsigned digits);
        int unsigned base;
        int unsigned off;
        base = 8 * digit;
        off  = 0;
        case (kind)
            0: off = (phase == 0) ? 6 : (phase == 1) ? 5 : 0;
            1: off = (phase == 0) ? 7 : (phase == 1) ? 1 : 4;
            default: off = (phase == 0) ? 2 : 3;
        endcase
        if (kind >= 2 && phase >= 2) return 8 * digits + digit;
        return base + off;
    endfunction

    function automatic lvl_e plane_level(logic active, logic late);
        if (active) return late ? LVL_GND : LVL_FULL;
        return late ? LVL_TWO3 : LVL_THIRD;
    endfunction

    function automatic lvl_e segment_level(logic lit, logic late);
        if (lit) return late ? LVL_FULL : LVL_GND;
        return late ? LVL_THIRD : LVL_TWO3;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_scan_pkg::*;
#(
    parameter int PHASE_LEN = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      osc_tick,
    input  logic      ext_osc,
    input  logic      sync_wr,
    input  pin_cfg_t  cfg,
    output scan_pos_t pos,
    output logic      adv,
    output logic      osc_q
);
    localparam int SUB_W = (PHASE_LEN > 2) ? $clog2(PHASE_LEN) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PHASE_LEN - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(PHASE_LEN / 2);

    logic [SUB_W-1:0] sub;
    logic [1:0]       phase;
    logic             ext_q;

    assign adv = cfg.use_ext ? (ext_osc & ~ext_q) : osc_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            osc_q <= 1'b0;
        end else begin
            ext_q <= ext_osc;
            osc_q <= osc_tick & ~cfg.use_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sync_wr) begin
            sub   <= '0;
            phase <= 2'd0;
        end else if (adv) begin
            if (sub == SUB_LAST) begin
                sub   <= '0;
                phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign pos.phase = phase;
    assign pos.late  = (sub >= SUB_HALF);
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
    import lcd_scan_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [9*DIGITS-1:0] seg_bits,
    input  logic [1:0]          phase,
    output logic [3*DIGITS-1:0] seg_on
);
    for (genvar k = 0; k < 3; k++) begin : g_kind
        for (genvar d = 0; d < DIGITS; d++) begin : g_digit
            localparam int unsigned IA = map_bit(k, d, 0, DIGITS);
            localparam int unsigned IB = map_bit(k, d, 1, DIGITS);
            localparam int unsigned IC = map_bit(k, d, 2, DIGITS);
            always_comb begin
                case (phase)
                    2'd0:    seg_on[k*DIGITS+d] = seg_bits[IA];
                    2'd1:    seg_on[k*DIGITS+d] = seg_bits[IB];
                    default: seg_on[k*DIGITS+d] = seg_bits[IC];
                endcase
            end
        end
    end
endmodule

// File: rtl/lcd_level_drive.sv
module lcd_level_drive
    import lcd_scan_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  scan_pos_t           pos,
    input  pin_cfg_t            cfg,
    input  logic                osc_q,
    input  logic [3*DIGITS-1:0] seg_on,
    output logic [5:0]          bp_code,
    output logic [6*DIGITS-1:0] seg_code
);
    for (genvar i = 0; i < 3; i++) begin : g_plane
        lvl_e lvl;
        assign lvl = plane_level(pos.phase == 2'(i), pos.late);
        if (i == 0) begin : g_a
            assign bp_code[1:0] = cfg.a_drive ? lvl : LVL_GND;
        end else if (i == 2) begin : g_c
            assign bp_code[5:4] = cfg.c_osc ? (osc_q ? LVL_FULL : LVL_GND) : lvl;
        end else begin : g_b
            assign bp_code[2*i +: 2] = lvl;
        end
    end

    for (genvar j = 0; j < 3*DIGITS; j++) begin : g_seg
        assign seg_code[2*j +: 2] = segment_level(seg_on[j], pos.late);
    end
endmodule

// File: rtl/lcd_scan_driver.sv
module lcd_scan_driver
    import lcd_scan_pkg::*;
#(
    parameter int PHASE_LEN = 64,
    parameter int DIGITS    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                osc_tick,
    input  logic                ext_osc,
    input  logic [1:0]          mode,
    input  logic                sync_wr,
    input  logic [9*DIGITS-1:0] seg_bits,
    output logic [5:0]          bp_code,
    output logic [6*DIGITS-1:0] seg_code,
    output logic                pin_a_oe,
    output logic                pin_c_osc
);
    pin_cfg_t            cfg;
    scan_pos_t           pos;
    logic                adv;
    logic                osc_q;
    logic [3*DIGITS-1:0] seg_on;

    assign cfg       = decode_role(role_e'(mode));
    assign pin_a_oe  = cfg.a_drive;
    assign pin_c_osc = cfg.c_osc;

    lcd_frame_timer #(.PHASE_LEN(PHASE_LEN)) u_timer (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .ext_osc(ext_osc),
        .sync_wr(sync_wr), .cfg(cfg), .pos(pos), .adv(adv), .osc_q(osc_q)
    );

    lcd_seg_map #(.DIGITS(DIGITS)) u_map (
        .seg_bits(seg_bits), .phase(pos.phase), .seg_on(seg_on)
    );

    lcd_level_drive #(.DIGITS(DIGITS)) u_drive (
        .pos(pos), .cfg(cfg), .osc_q(osc_q), .seg_on(seg_on),
        .bp_code(bp_code), .seg_code(seg_code)
    );
endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker (
    input logic       clk,
    input logic       rst,
    input logic       osc_tick,
    input logic [1:0] mode,
    input logic       sync_wr,
    input logic [1:0] phase,
    input logic       late,
    input logic       adv,
    input logic       use_ext,
    input logic [5:0] bp_code,
    input logic       pin_a_oe,
    input logic       pin_c_osc
);
    logic [2:0] plane_on;
    for (genvar i = 0; i < 3; i++) begin : g_on
        assign plane_on[i] = (bp_code[2*i +: 2] == 2'd3) || (bp_code[2*i +: 2] == 2'd0);
    end

    p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);

    p_one_active_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_a_oe && !pin_c_osc) |-> $countones(plane_on) == 1);

    p_slave_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (use_ext && !adv && !sync_wr) |=> ($stable(phase) && $stable(late)));

    p_sync_clear_r8: assert property (@(posedge clk) disable iff (rst)
        sync_wr |=> (phase == 2'd0 && !late));

    p_osc_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (osc_tick && mode == 2'b00) |=> (mode != 2'b00 || bp_code[5:4] == 2'd3));

    p_a_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !pin_a_oe |-> bp_code[1:0] == 2'd0);
endmodule

bind lcd_scan_driver lcd_scan_checker u_chk (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .mode(mode), .sync_wr(sync_wr),
    .phase(pos.phase), .late(pos.late), .adv(adv), .use_ext(cfg.use_ext),
    .bp_code(bp_code), .pin_a_oe(pin_a_oe), .pin_c_osc(pin_c_osc)
);

// File: tb/tb_lcd_scan_driver.sv
`timescale 1ns/1ps
module tb_lcd_scan_driver;
    localparam int PL = 64;
    localparam int ND = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            osc_tick = 1'b0;
    logic            ext_osc = 1'b0;
    logic [1:0]      mode = 2'b01;
    logic            sync_wr = 1'b0;
    logic [9*ND-1:0] seg_bits = '0;
    logic [5:0]      bp_code;
    logic [6*ND-1:0] seg_code;
    logic            pin_a_oe;
    logic            pin_c_osc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit cmp_on = 0;

    lcd_scan_driver #(.PHASE_LEN(PL), .DIGITS(ND)) dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .ext_osc(ext_osc),
        .mode(mode), .sync_wr(sync_wr), .seg_bits(seg_bits),
        .bp_code(bp_code), .seg_code(seg_code),
        .pin_a_oe(pin_a_oe), .pin_c_osc(pin_c_osc)
    );

    always #2 clk = ~clk;

    // expected bit per (kind, digit, phase), built from the numbered bit list
    int emap [3][ND][3];
    initial begin
        int kind_of [8] = '{0, 1, 2, 2, 1, 0, 0, 1};
        int bp_of   [8] = '{2, 1, 0, 1, 2, 1, 0, 0};
        for (int b = 0; b < 8*ND; b++) emap[kind_of[b%8]][b/8][bp_of[b%8]] = b;
        for (int d = 0; d < ND; d++) emap[2][d][2] = 8*ND + d;
    end

    // behavioural model
    int  m_cnt = 0;
    bit  m_ext = 0;
    bit  m_osc = 0;
    always @(posedge clk) begin
        bit step;
        step = (mode == 2'b11) ? (ext_osc && !m_ext) : osc_tick;
        if (rst) begin
            m_cnt = 0; m_ext = 0; m_osc = 0;
        end else begin
            if (sync_wr) m_cnt = 0;
            else if (step) m_cnt = (m_cnt + 1) % (3*PL);
            m_ext = ext_osc;
            m_osc = osc_tick && (mode != 2'b11);
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int plane_exp(int i, int ph, bit late);
        if (i == ph) return late ? 0 : 3;
        return late ? 2 : 1;
    endfunction

    function automatic int seg_exp(bit lit, bit late);
        if (lit) return late ? 3 : 0;
        return late ? 1 : 2;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            int  ph;
            bit  late;
            bit  a_oe;
            bit  c_osc;
            ph    = m_cnt / PL;
            late  = (m_cnt % PL) >= PL/2;
            a_oe  = (mode == 2'b00) || (mode == 2'b01);
            c_osc = (mode == 2'b00) || (mode == 2'b10);
            chk("R10 oe", pin_a_oe, a_oe);
            chk("R9 osc flag", pin_c_osc, c_osc);
            chk(a_oe ? "R3 bpA" : "R10 bpA", bp_code[1:0], a_oe ? plane_exp(0, ph, late) : 0);
            chk("R3 bpB", bp_code[3:2], plane_exp(1, ph, late));
            chk(c_osc ? "R9 bpC" : "R3 bpC", bp_code[5:4], c_osc ? (m_osc ? 3 : 0) : plane_exp(2, ph, late));
            for (int k = 0; k < 3; k++)
                for (int d = 0; d < ND; d++) begin
                    int j;
                    j = 4*k + d;
                    chk((k == 2 && ph == 2) ? "R6 seg" : "R5 seg", seg_code[2*j +: 2],
                        seg_exp(seg_bits[emap[k][d][ph]], late));
                end
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1; cyc(1); osc_tick = 1'b0; cyc(gap);
        end
    endtask

    task automatic do_sync();
        sync_wr = 1'b1; cyc(1); sync_wr = 1'b0;
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1: start of frame after reset
        chk("R1 bpA", bp_code[1:0], 3);
        chk("R1 bpB", bp_code[3:2], 1);
        chk("R1 seg dark", seg_code[1:0], 2);
        cyc(1);

        // R2: phase lengths and wrap in stand-alone role
        seg_bits = 36'h9_A5C3_1E7B;
        do_sync();
        ticks(PL, 0);
        @(negedge clk);
        chk("R2 second phase", bp_code[3:2], 3);
        cyc(1);
        ticks(2*PL, 0);
        @(negedge clk);
        chk("R2 wrap", bp_code[1:0], 3);
        chk("R2 wrap C idle", bp_code[5:4], 1);
        cyc(1);

        // R4: all lit, first half
        seg_bits = '1;
        do_sync();
        @(negedge clk);
        chk("R4 lit early", seg_code[3:2], 0);
        cyc(1);
        ticks(PL/2, 0);
        @(negedge clk);
        chk("R4 lit late", seg_code[3:2], 3);
        cyc(1);

        // R5/R6: walk one bit over a full frame each
        for (int b = 0; b < 9*ND; b++) begin
            seg_bits = '0;
            seg_bits[b] = 1'b1;
            ticks(3*PL/4, 0);
            ticks(PL/4, 2);
        end

        // R8: sync beats a pending tick mid-phase
        seg_bits = 36'h5_3C96_A0F1;
        ticks(PL + 7, 0);
        sync_wr = 1'b1; osc_tick = 1'b1; cyc(1); sync_wr = 1'b0; osc_tick = 1'b0;
        @(negedge clk);
        chk("R8 restart", bp_code[1:0], 3);
        cyc(1);

        // R9: master role, oscillator copy on third pin
        mode = 2'b00;
        ticks(3*PL, 2);
        osc_tick = 1'b1; cyc(1); osc_tick = 1'b0;
        @(negedge clk);
        chk("R9 copy high", bp_code[5:4], 3);
        cyc(1);
        @(negedge clk);
        chk("R9 copy low", bp_code[5:4], 0);
        cyc(1);

        // R7: slave role, ticks ignored, ext edges step
        mode = 2'b11;
        do_sync();
        ticks(PL, 0);
        @(negedge clk);
        chk("R7 ticks ignored", bp_code[3:2], 1);
        chk("R10 slave A", bp_code[1:0], 0);
        cyc(1);
        for (int i = 0; i < 3*PL + 20; i++) begin
            ext_osc = 1'b1; osc_tick = (i % 3 == 0); cyc(2);
            ext_osc = 1'b0; osc_tick = 1'b0; cyc(1);
        end
        do_sync();
        for (int i = 0; i < PL; i++) begin
            ext_osc = 1'b1; cyc(1); ext_osc = 1'b0; cyc(1);
        end
        @(negedge clk);
        chk("R7 ext edges", bp_code[3:2], 3);
        cyc(1);

        // R10: reserved role
        mode = 2'b10;
        ticks(3*PL, 1);
        mode = 2'b01;
        ticks(PL, 0);

        cmp_on = 1'b0;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule